// File: doc/BRIEF.md
# Row-Multiplexed Dot-Matrix Refresh and Dimming Controller

This block refreshes a four-character 5x7 dot-matrix display one row at a time. A free-running timebase splits time into row slots of 32 clocks and steps through the seven rows in turn. Each clock is one oscillator tick. During the last few ticks of a slot, the block asks an external combinational glyph decoder for the five-dot pattern of the next row of each character, one character per clock. It holds the answers in a staging buffer and moves them to the drive registers when the slot changes. The row select and the staged patterns therefore change on the same clock edge.

The register contents are supplied from outside the block: the character codes, the per-digit cursor bits, the per-digit blank-exempt bits, the brightness code, the master blank bit and the extended-disable bit. Each digit's column enables are then gated by several things: a dimming window whose length comes from the brightness code, blanking from the blank pin and the master blank bit (a digit's exempt bit overrides both), and a cursor mode that lights all dots of a digit at half the on-time. The control and pin inputs act on the column outputs combinationally, in the same cycle. The block holds no register data of its own beyond the row patterns, so blanking and dimming never alter stored contents.

Top module: `dmx_refresh`

## Requirements
- R1: While reset is high and on the first cycle after it, `row_sel` is 7'b1000000 (row 6), the tick count is 0 and no digit pattern is loaded. A non-cursor digit shows all columns off during the first slot after reset.
- R2: Each row slot lasts exactly 32 clocks. Rows advance 0,1,...,6 and then wrap to 0. `row_sel` has bit r set for row r and all other bits clear.
- R3: At tick 27+d of a slot (d = 0..3), `glyph_code` equals the code of digit d (bits 7d+6:7d of `char_codes`) and `glyph_row` equals the next row. The 5-bit answer is the pattern shown for digit d (bits 5d+4:5d of `col_en`) throughout the following slot.
- R4: At tick 0 of every slot, all 20 column enables are 0.
- R5: A lit non-cursor digit drives its pattern at ticks 1..N and 0 otherwise. N is 31, 19, 13, 9, 5, 3, 2 or 1 for brightness codes 0 to 7.
- R6: A digit is dark whenever `blank_n` is 0 or `master_blank` is 1, unless its `blank_exempt` bit is 1.
- R7: When `cursor_en` is 1 and a digit's cursor bit is 1, that digit drives 5'b11111 at ticks 1..max(1, floor(N/2)) and is subject to blanking as in R6.
- R8: When `cursor_en` is 0, every digit shows its character pattern regardless of its cursor bit.
- R9: When `ext_disable` is 1, the block behaves as if the brightness code were 0, `master_blank` were 0 and all `blank_exempt` bits were 0. The cursor still works as in R7 and the blank pin still blanks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| char_codes | input | 28 | Four 7-bit character codes, digit d at bits 7d+6:7d |
| cursor_bits | input | 4 | Per-digit cursor bit |
| blank_exempt | input | 4 | Per-digit exemption from blanking |
| bright_code | input | 3 | Brightness code, 0 = full on-time |
| master_blank | input | 1 | Blanks all non-exempt digits |
| ext_disable | input | 1 | Forces full brightness, no master blank, no exemption |
| cursor_en | input | 1 | Enables cursor display |
| blank_n | input | 1 | Blank pin, active low |
| glyph_code | output | 7 | Character code presented to the glyph decoder |
| glyph_row | output | 3 | Row index presented to the glyph decoder |
| glyph_bits | input | 5 | Decoder answer for glyph_code and glyph_row |
| row_sel | output | 7 | One-hot row select |
| col_en | output | 20 | Column enables, digit d at bits 5d+4:5d |

## Verification
The decoder request for digit d is due combinationally at tick 27+d. Its answer appears on the columns one clock after tick 31, when the row select also changes. The bench keeps its own cycle count from reset release, derives the tick and row from that count, and works out the expected patterns at tick 31 from the codes it is holding. The control inputs act on the columns in the same cycle. The bench therefore changes them only at tick 0, just after a falling edge, waits one time unit, and checks every tick of the slot at the falling edge. It changes the character codes only at tick 0, well before the fetch window.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int DIGITS_D = 4;
    localparam int CODE_W_D = 7;
    localparam int COLS_D   = 5;
    localparam int ROWS_D   = 7;
    localparam int SLOT_D   = 32;

    typedef enum logic [1:0] {
        GATE_DARK   = 2'd0,
        GATE_GLYPH  = 2'd1,
        GATE_CURSOR = 2'd2
    } gate_mode_e;

    typedef struct packed {
        logic [2:0] bright;
        logic       mblank;
        logic [DIGITS_D-1:0] exempt;
    } eff_ctrl_t;

    // Ticks of full-slot on-time per brightness code (before capping).
    function automatic int duty_ticks(input logic [2:0] code);
        case (code)
            3'd0:    return 32;
            3'd1:    return 19;
            3'd2:    return 13;
            3'd3:    return 9;
            3'd4:    return 5;
            3'd5:    return 3;
            3'd6:    return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int half_ticks(input int full);
        int h;
        h = full / 2;
        return (h < 1) ? 1 : h;
    endfunction

endpackage

// File: rtl/dmx_timebase.sv
module dmx_timebase #(
    parameter int SLOT_N = 32,
    parameter int ROW_N  = 7,
    localparam int TICK_W = $clog2(SLOT_N),
    localparam int ROW_W  = $clog2(ROW_N)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TICK_W-1:0] tick_q,
    output logic [ROW_W-1:0]  row_q,
    output logic [ROW_W-1:0]  next_row,
    output logic              slot_end
);

    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SLOT_N - 1);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(ROW_N - 1);

    assign slot_end = (tick_q == LAST_TICK);
    assign next_row = (row_q == LAST_ROW) ? '0 : row_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            row_q  <= LAST_ROW;
        end else begin
            tick_q <= slot_end ? '0 : tick_q + 1'b1;
            if (slot_end)
                row_q <= next_row;
        end
    end

    a_r2_row_holds: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(row_q));
    a_r2_row_range: assert property (@(posedge clk) disable iff (rst)
        row_q <= LAST_ROW);
    a_r2_tick_wraps: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> tick_q == '0);

endmodule

// File: rtl/dmx_fetch.sv
module dmx_fetch #(
    parameter int DIGITS = 4,
    parameter int CODE_W = 7,
    parameter int COLS   = 5,
    parameter int SLOT_N = 32,
    parameter int ROW_W  = 3,
    localparam int TICK_W = $clog2(SLOT_N),
    localparam int DIG_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TICK_W-1:0]        tick,
    input  logic [ROW_W-1:0]         next_row,
    input  logic                     slot_end,
    input  logic [DIGITS*CODE_W-1:0] char_codes,
    input  logic [COLS-1:0]          glyph_bits,
    output logic [CODE_W-1:0]        glyph_code,
    output logic [ROW_W-1:0]         glyph_row,
    output logic [DIGITS*COLS-1:0]   pattern
);

    // Fetch window ends one tick before the slot boundary.
    localparam logic [TICK_W-1:0] FETCH_START = TICK_W'(SLOT_N - 1 - DIGITS);
    localparam logic [TICK_W-1:0] FETCH_STOP  = TICK_W'(SLOT_N - 1);

    logic              fetch_active;
    logic [DIG_W-1:0]  fetch_idx;
    logic [TICK_W-1:0] rel_tick;
    logic [COLS-1:0]   stage   [DIGITS];
    logic [COLS-1:0]   shown   [DIGITS];

    assign fetch_active = (tick >= FETCH_START) && (tick < FETCH_STOP);
    assign rel_tick     = tick - FETCH_START;
    assign fetch_idx    = fetch_active ? rel_tick[DIG_W-1:0] : '0;
    assign glyph_code   = char_codes[fetch_idx*CODE_W +: CODE_W];
    assign glyph_row    = next_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DIGITS; d++) begin
                stage[d] <= '0;
                shown[d] <= '0;
            end
        end else begin
            if (fetch_active)
                stage[fetch_idx] <= glyph_bits;
            if (slot_end)
                for (int d = 0; d < DIGITS; d++)
                    shown[d] <= stage[d];
        end
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_flat
        assign pattern[g*COLS +: COLS] = shown[g];
    end

    a_r3_capture_first: assert property (@(posedge clk) disable iff (rst)
        (fetch_active && fetch_idx == '0) |=> stage[0] == $past(glyph_bits));
    a_r3_shown_stable: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(pattern));

endmodule

// File: rtl/dmx_digit_gate.sv
module dmx_digit_gate
    import dmx_pkg::*;
#(
    parameter int COLS   = 5,
    parameter int SLOT_N = 32,
    localparam int TICK_W = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] tick,
    input  logic [COLS-1:0]   glyph,
    input  logic              cursor_on,
    input  logic              blanked,
    input  logic [TICK_W:0]   full_limit,
    input  logic [TICK_W:0]   half_limit,
    output logic [COLS-1:0]   cols
);

    gate_mode_e      mode;
    logic [TICK_W:0] limit;
    logic [TICK_W:0] tick_x;
    logic            in_window;

    assign tick_x = {1'b0, tick};

    always_comb begin
        if (blanked)        mode = GATE_DARK;
        else if (cursor_on) mode = GATE_CURSOR;
        else                mode = GATE_GLYPH;
    end

    assign limit     = (mode == GATE_CURSOR) ? half_limit : full_limit;
    assign in_window = (tick_x >= 1) && (tick_x <= limit);

    always_comb begin
        unique case (mode)
            GATE_GLYPH:  cols = in_window ? glyph : '0;
            GATE_CURSOR: cols = in_window ? '1 : '0;
            default:     cols = '0;
        endcase
    end

    a_r6_blank_dark: assert property (@(posedge clk) disable iff (rst)
        blanked |-> cols == '0);
    a_r5_outside_window: assert property (@(posedge clk) disable iff (rst)
        (tick_x > full_limit) |-> cols == '0);

endmodule

// File: rtl/dmx_refresh.sv
module dmx_refresh
    import dmx_pkg::*;
#(
    parameter int DIGITS = DIGITS_D,
    parameter int CODE_W = CODE_W_D,
    parameter int COLS   = COLS_D,
    parameter int ROWS   = ROWS_D,
    parameter int SLOT_N = SLOT_D,
    localparam int TICK_W = $clog2(SLOT_N),
    localparam int ROW_W  = $clog2(ROWS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DIGITS*CODE_W-1:0] char_codes,
    input  logic [DIGITS-1:0]        cursor_bits,
    input  logic [DIGITS-1:0]        blank_exempt,
    input  logic [2:0]               bright_code,
    input  logic                     master_blank,
    input  logic                     ext_disable,
    input  logic                     cursor_en,
    input  logic                     blank_n,
    output logic [CODE_W-1:0]        glyph_code,
    output logic [ROW_W-1:0]         glyph_row,
    input  logic [COLS-1:0]          glyph_bits,
    output logic [ROWS-1:0]          row_sel,
    output logic [DIGITS*COLS-1:0]   col_en
);

    localparam int MAX_ON = SLOT_N - 1;

    logic [TICK_W-1:0]      tick_q;
    logic [ROW_W-1:0]       row_q;
    logic [ROW_W-1:0]       next_row;
    logic                   slot_end;
    logic [DIGITS*COLS-1:0] pattern;
    eff_ctrl_t              eff;
    logic [TICK_W:0]        full_limit;
    logic [TICK_W:0]        half_limit;

    dmx_timebase #(.SLOT_N(SLOT_N), .ROW_N(ROWS)) u_time (
        .clk(clk), .rst(rst), .tick_q(tick_q), .row_q(row_q),
        .next_row(next_row), .slot_end(slot_end)
    );

    dmx_fetch #(
        .DIGITS(DIGITS), .CODE_W(CODE_W), .COLS(COLS),
        .SLOT_N(SLOT_N), .ROW_W(ROW_W)
    ) u_fetch (
        .clk(clk), .rst(rst), .tick(tick_q), .next_row(next_row),
        .slot_end(slot_end), .char_codes(char_codes),
        .glyph_bits(glyph_bits), .glyph_code(glyph_code),
        .glyph_row(glyph_row), .pattern(pattern)
    );

    // Extended-disable overrides brightness, master blank and exemptions.
    always_comb begin
        eff.bright = ext_disable ? 3'd0 : bright_code;
        eff.mblank = master_blank & ~ext_disable;
        eff.exempt = ext_disable ? '0 : blank_exempt;
    end

    always_comb begin
        int full;
        full = duty_ticks(eff.bright);
        if (full > MAX_ON)
            full = MAX_ON;
        full_limit = (TICK_W+1)'(full);
        half_limit = (TICK_W+1)'(half_ticks(full));
    end

    always_comb begin
        row_sel = '0;
        row_sel[row_q] = 1'b1;
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic blanked_g;
        logic cursor_g;
        assign blanked_g = (~blank_n | eff.mblank) & ~eff.exempt[g];
        assign cursor_g  = cursor_en & cursor_bits[g];

        dmx_digit_gate #(.COLS(COLS), .SLOT_N(SLOT_N)) u_gate (
            .clk(clk), .rst(rst), .tick(tick_q),
            .glyph(pattern[g*COLS +: COLS]), .cursor_on(cursor_g),
            .blanked(blanked_g), .full_limit(full_limit),
            .half_limit(half_limit), .cols(col_en[g*COLS +: COLS])
        );
    end

    a_r4_first_tick_dark: assert property (@(posedge clk) disable iff (rst)
        (tick_q == '0) |-> col_en == '0);
    a_r2_row_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(row_sel) == 1);
    a_r9_ext_full_on: assert property (@(posedge clk) disable iff (rst)
        ext_disable |-> full_limit == (TICK_W+1)'(MAX_ON));

endmodule

// File: tb/dmx_refresh_test.sv
module dmx_refresh_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [27:0] char_codes;
    logic [3:0]  cursor_bits, blank_exempt;
    logic [2:0]  bright_code;
    logic        master_blank, ext_disable, cursor_en, blank_n;
    logic [6:0]  glyph_code;
    logic [2:0]  glyph_row;
    logic [4:0]  glyph_bits;
    logic [6:0]  row_sel;
    logic [19:0] col_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    function automatic logic [4:0] dec(input logic [6:0] c, input logic [2:0] r);
        return 5'((c + r * 7) ^ (c >> 2));
    endfunction

    assign glyph_bits = dec(glyph_code, glyph_row);

    dmx_refresh uut (
        .clk(clk), .rst(rst), .char_codes(char_codes),
        .cursor_bits(cursor_bits), .blank_exempt(blank_exempt),
        .bright_code(bright_code), .master_blank(master_blank),
        .ext_disable(ext_disable), .cursor_en(cursor_en), .blank_n(blank_n),
        .glyph_code(glyph_code), .glyph_row(glyph_row),
        .glyph_bits(glyph_bits), .row_sel(row_sel), .col_en(col_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int on_ticks(input logic [2:0] b);
        int n;
        case (b)
            3'd0: n = 31; 3'd1: n = 19; 3'd2: n = 13; 3'd3: n = 9;
            3'd4: n = 5;  3'd5: n = 3;  3'd6: n = 2;  default: n = 1;
        endcase
        return n;
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] exp_pat [4];
        rst = 1'b1;
        char_codes = '0; cursor_bits = '0; blank_exempt = '0;
        bright_code = '0; master_blank = 0; ext_disable = 0;
        cursor_en = 0; blank_n = 1;
        for (int d = 0; d < 4; d++) exp_pat[d] = '0;
        repeat (3) @(negedge clk);
        chk("R1 row", 32'(row_sel), 32'h40);
        chk("R1 cols", 32'(col_en), 32'h0);
        rst = 1'b0;
        for (int cyc = 0; cyc < 128 * 32 + 7 * 32; cyc++) begin
            int t, slot, row, nrow, n, w, idx;
            t    = cyc % 32;
            slot = cyc / 32;
            row  = (slot + 6) % 7;
            nrow = (row + 1) % 7;
            idx  = slot % 128;
            if (t == 0) begin
                bright_code  = 3'(idx);
                ext_disable  = idx[3];
                master_blank = idx[4];
                blank_n      = idx[5];
                cursor_en    = idx[6];
                cursor_bits  = 4'((idx * 5) ^ 3);
                blank_exempt = 4'((idx * 3) >> 1);
                for (int d = 0; d < 4; d++)
                    char_codes[d*7 +: 7] = 7'(slot * 13 + d * 29 + 5);
            end
            #1;
            chk("R2 row_sel", 32'(row_sel), 32'(1 << row));
            if (t >= 27 && t <= 30) begin
                chk("R3 glyph_code", 32'(glyph_code), 32'(char_codes[(t-27)*7 +: 7]));
                chk("R3 glyph_row", 32'(glyph_row), 32'(nrow));
            end
            n = on_ticks(ext_disable ? 3'd0 : bright_code);
            for (int d = 0; d < 4; d++) begin
                logic bl, cu, on;
                logic [4:0] p, e;
                string tag;
                bl = (!blank_n || (master_blank && !ext_disable)) &&
                     !(blank_exempt[d] && !ext_disable);
                cu = cursor_en && cursor_bits[d];
                w  = cu ? ((n / 2 < 1) ? 1 : n / 2) : n;
                p  = cu ? 5'h1F : exp_pat[d];
                on = !bl && t >= 1 && t <= w;
                e  = on ? p : 5'h0;
                if (t == 0)                          tag = "R4 tick0 dark";
                else if (slot == 0 && !cu)           tag = "R1 no pattern";
                else if (ext_disable)                tag = "R9 ext disable";
                else if (bl || (!blank_n && blank_exempt[d]) ||
                         (master_blank && blank_exempt[d])) tag = "R6 blanking";
                else if (cu)                         tag = "R7 cursor";
                else if (!cursor_en && cursor_bits[d]) tag = "R8 cursor off";
                else                                 tag = "R5 dimming";
                chk(tag, 32'(col_en[d*5 +: 5]), 32'(e));
            end
            if (t == 31)
                for (int d = 0; d < 4; d++)
                    exp_pat[d] = dec(char_codes[d*7 +: 7], 3'(nrow));
            @(negedge clk);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule